// File: doc/BRIEF.md
# SPI ADC Command Slave

This block is the digital front end of an eight-channel, ten-bit converter that answers as an SPI slave in mode 0. A host pulls the active-low select low and clocks three bytes through. The first byte is a start marker. The second byte carries a mode flag and a channel number. While those bytes arrive, the slave shifts back a reply whose second and third bytes hold the chosen channel's ten-bit code. The analog core is outside the block. Each channel's conversion result reaches it as a ten-bit input word.

Everything runs on a system clock that is much faster than SCK. SCK, MOSI and the select pass through a synchronizer, and an edge detector turns them into single-cycle strobes. A frame state machine advances on those strobes through five states:

- `ST_IDLE`: select high.
- `ST_START`: receiving the start byte.
- `ST_SELECT`: receiving the mode and channel bits.
- `ST_DATA`: the rest of the frame.
- `ST_DONE`: past the third byte.

The transitions are:

- `T_SELECT_CHIP`: a falling select moves `ST_IDLE` to `ST_START`.
- `T_START_DONE`: the eighth rising SCK moves `ST_START` to `ST_SELECT`.
- `T_LATCH`: the fourth bit of the second byte moves `ST_SELECT` to `ST_DATA`. The sample is captured on this step.
- `T_FRAME_END`: the last bit of the third byte moves `ST_DATA` to `ST_DONE`.
- `T_DESELECT`: a high select returns any state to `ST_IDLE`.

A serializer drives MISO from the bit count and the captured result.

Top module: `adc_cmd_slave`

## Requirements
- R1: Bytes move MSB first. A frame is three bytes, and the reply bits during the first byte are all zero.
- R2: A falling edge on the select clears the bit and byte counters. A frame cut short and followed by a new select is decoded from scratch.
- R3: MOSI and SCK activity while the select is high changes nothing in the next frame.
- R4: A frame whose first byte is not 0x01 returns zero in both result bytes.
- R5: In the second byte, bit 7 = 1 selects single-ended mode and bits 6:4 give the channel, 0 to 7. In single-ended mode the reply carries that channel's input code.
- R6: The second reply byte is six zero bits followed by result bits 9:8. The third reply byte is result bits 7:0.
- R7: When bit 7 of the second byte is 0 (differential mode), both result bytes are zero.
- R8: The channel code is captured when bit 4 of the second byte is received. Later changes to that input do not alter the reply of the current frame.
- R9: MISO is low while the select is high. Reply bits after the 24th bit are zero.
- R10: MOSI is sampled on rising SCK and MISO changes only after falling SCK, so MISO holds steady through each high phase of SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | SPI serial clock from the host |
| mosi_in | input | 1 | Serial data from the host |
| csel_n | input | 1 | Active-low chip select |
| samples_in | input | NUM_CH*CODE_W | Channel codes; channel k occupies bits k*CODE_W and up |
| miso_out | output | 1 | Serial reply to the host |

## Verification
The bench targets four cases:

- A sample that changes right after the capture point. A design that captures late would return the new value.
- A frame aborted after a few bits and followed by a fresh select. Counters that are not cleared would shift every reply.
- Start bytes that are close to 0x01 but wrong. A loose compare would return real codes for them.
- A fourth byte clocked past the end of the frame. A serializer that runs off the end would shift out stale result bits.

The bench also checks that MISO holds its value across each SCK high phase, which exposes a serializer that updates on the wrong edge.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SELECT,
        ST_DATA,
        ST_DONE
    } frame_state_e;

    localparam int BYTE_W       = 8;
    localparam int FRAME_BYTES  = 3;
    localparam int CH_FIELD_W   = 3;
    localparam logic [BYTE_W-1:0] START_CODE = 8'h01;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic mosi_in,
    input  logic csel_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_hi,
    output logic mosi_s
);
    localparam int SIG_N = 3;
    localparam logic [SIG_N-1:0] RST_VAL = 3'b100;

    logic [STAGES-1:0][SIG_N-1:0] chain;
    logic [SIG_N-1:0] synced;
    logic sck_prev;
    logic cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= {csel_n, sck_in, mosi_in};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign synced = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= synced[1];
            cs_prev  <= synced[2];
        end
    end

    assign cs_hi    = synced[2];
    assign cs_fall  = cs_prev & ~synced[2];
    assign sck_rise = ~sck_prev & synced[1] & ~synced[2];
    assign sck_fall = sck_prev & ~synced[1] & ~synced[2];
    assign mosi_s   = synced[0];

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_cmd_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              mosi_s,
    input  logic [CODE_W-1:0] chan_code [NUM_CH],
    output frame_state_e      state,
    output logic [2:0]        bit_cnt,
    output logic [1:0]        byte_idx,
    output logic [CODE_W-1:0] result_q
);
    localparam logic [1:0] LAST_BYTE = 2'(FRAME_BYTES - 1);
    localparam logic [1:0] PAST_END  = 2'(FRAME_BYTES);

    frame_state_e            nxt;
    logic [BYTE_W-1:0]       sr;
    logic                    start_ok;
    logic [CH_FIELD_W-1:0]   ch_sel;
    logic                    mode_se;
    logic [CODE_W-1:0]       pick;
    logic [BYTE_W-1:0]       byte_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (cs_hi) begin
            nxt = ST_IDLE;                                           // T_DESELECT
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) nxt = ST_START;              // T_SELECT_CHIP
                ST_START:  if (sck_rise && bit_cnt == 3'd7) nxt = ST_SELECT;   // T_START_DONE
                ST_SELECT: if (sck_rise && bit_cnt == 3'd3) nxt = ST_DATA;     // T_LATCH
                ST_DATA:   if (sck_rise && bit_cnt == 3'd7 && byte_idx == LAST_BYTE)
                               nxt = ST_DONE;                        // T_FRAME_END
                ST_DONE:   nxt = ST_DONE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    assign byte_in = {sr[BYTE_W-2:0], mosi_s};
    assign mode_se = sr[2];
    assign ch_sel  = {sr[1:0], mosi_s};

    always_comb begin
        pick = '0;
        if (start_ok && mode_se && (int'(ch_sel) < NUM_CH))
            pick = chan_code[ch_sel];
    end

    // datapath outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            sr       <= '0;
            start_ok <= 1'b0;
            result_q <= '0;
        end else if (cs_hi || cs_fall) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            sr       <= '0;
            start_ok <= 1'b0;
            result_q <= '0;
        end else if (sck_rise && state != ST_IDLE) begin
            sr      <= byte_in;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && byte_idx != PAST_END)
                byte_idx <= byte_idx + 2'd1;
            if (state == ST_START && bit_cnt == 3'd7)
                start_ok <= (byte_in == START_CODE);
            if (state == ST_SELECT && bit_cnt == 3'd3)
                result_q <= pick;
        end
    end

endmodule

// File: rtl/adc_resp_shifter.sv
module adc_resp_shifter
    import adc_cmd_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              cs_fall,
    input  logic              sck_fall,
    input  logic [2:0]        bit_cnt,
    input  logic [1:0]        byte_idx,
    input  logic [CODE_W-1:0] result_q,
    output logic              miso
);
    localparam int RESP_W = 2 * BYTE_W;
    localparam int IDX_W  = $clog2(RESP_W);

    logic [RESP_W-1:0] word;
    logic [IDX_W-1:0]  pos;
    logic              in_reply;

    assign word     = RESP_W'(result_q);
    assign in_reply = (byte_idx == 2'd1) || (byte_idx == 2'd2);
    assign pos      = (byte_idx == 2'd1) ? IDX_W'(RESP_W - 1 - int'(bit_cnt))
                                         : IDX_W'(BYTE_W - 1 - int'(bit_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                miso <= 1'b0;
        else if (cs_hi || cs_fall) miso <= 1'b0;
        else if (sck_fall)         miso <= in_reply ? word[pos] : 1'b0;
    end

endmodule

// File: rtl/adc_cmd_slave.sv
module adc_cmd_slave
    import adc_cmd_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CODE_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_in,
    input  logic                     mosi_in,
    input  logic                     csel_n,
    input  logic [NUM_CH*CODE_W-1:0] samples_in,
    output logic                     miso_out
);
    logic              sck_rise_s;
    logic              sck_fall_s;
    logic              cs_fall_s;
    logic              cs_hi_s;
    logic              mosi_s;
    frame_state_e      state;
    logic [2:0]        bit_cnt;
    logic [1:0]        byte_idx;
    logic [CODE_W-1:0] result_q;
    logic [CODE_W-1:0] chan_code [NUM_CH];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
            assign chan_code[g] = samples_in[g*CODE_W +: CODE_W];
        end
    endgenerate

    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .mosi_in  (mosi_in),
        .csel_n   (csel_n),
        .sck_rise (sck_rise_s),
        .sck_fall (sck_fall_s),
        .cs_fall  (cs_fall_s),
        .cs_hi    (cs_hi_s),
        .mosi_s   (mosi_s)
    );

    adc_frame_fsm #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (cs_hi_s),
        .cs_fall   (cs_fall_s),
        .sck_rise  (sck_rise_s),
        .mosi_s    (mosi_s),
        .chan_code (chan_code),
        .state     (state),
        .bit_cnt   (bit_cnt),
        .byte_idx  (byte_idx),
        .result_q  (result_q)
    );

    adc_resp_shifter #(.CODE_W(CODE_W)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (cs_hi_s),
        .cs_fall  (cs_fall_s),
        .sck_fall (sck_fall_s),
        .bit_cnt  (bit_cnt),
        .byte_idx (byte_idx),
        .result_q (result_q),
        .miso     (miso_out)
    );

endmodule

// File: rtl/adc_cmd_slave_chk.sv
module adc_cmd_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       miso_out,
    input logic       cs_hi_s,
    input logic       cs_fall_s,
    input logic       sck_rise_s,
    input logic       sck_fall_s,
    input logic [2:0] bit_cnt,
    input logic [1:0] byte_idx
);
    AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi_s |=> !miso_out);                                       // R9

    AST_MISO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_out) |-> $past(sck_fall_s || cs_hi_s || cs_fall_s));   // R10

    AST_SELECT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall_s |=> (bit_cnt == 3'd0 && byte_idx == 2'd0));         // R2

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise_s && !cs_fall_s && bit_cnt == 3'd7 && byte_idx != 2'd3)
        |=> byte_idx == $past(byte_idx) + 2'd1);                      // R1

    AST_NO_COUNT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_hi_s) && cs_hi_s) |-> (bit_cnt == 3'd0 && byte_idx == 2'd0));   // R3
endmodule

bind adc_cmd_slave adc_cmd_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso_out   (miso_out),
    .cs_hi_s    (cs_hi_s),
    .cs_fall_s  (cs_fall_s),
    .sck_rise_s (sck_rise_s),
    .sck_fall_s (sck_fall_s),
    .bit_cnt    (bit_cnt),
    .byte_idx   (byte_idx)
);

// File: tb/tb_adc_cmd_slave.sv
module tb_adc_cmd_slave;
    localparam int CLK_P  = 10;
    localparam int HALF   = 8;
    localparam int NCH    = 8;
    localparam int CW     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic csel_n = 1'b1;
    logic [CW-1:0] codes [NCH];
    logic [NCH*CW-1:0] samples;
    logic miso;
    logic idle_mon = 1'b0;
    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) samples[i*CW +: CW] = codes[i];
    end

    adc_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .sck_in(sck), .mosi_in(mosi),
        .csel_n(csel_n), .samples_in(samples), .miso_out(miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock reference: deselected slave keeps MISO low (R9)
    always @(negedge clk) begin
        if (idle_mon) begin
            n_tests++;
            if (miso !== 1'b0) begin
                n_fail++;
                $display("FAIL R9: actual %b expected 0 while deselected", miso);
            end
        end
    end

    task automatic half_p();
        repeat (HALF) @(negedge clk);
    endtask

    function automatic logic [31:0] model(input logic [7:0] b0, input logic [7:0] b1);
        logic [CW-1:0] res;
        res = (b0 == 8'h01 && b1[7]) ? codes[b1[6:4]] : '0;
        return {8'h00, 6'b0, res[9:8], res[7:0], 8'h00};
    endfunction

    task automatic xfer(input logic [31:0] tx, input int nbits, input int mut_at,
                        input int mch, input logic [CW-1:0] mval,
                        output logic [31:0] rx, output logic [31:0] rx_hi);
        rx = '0; rx_hi = '0;
        idle_mon = 1'b0;
        csel_n = 1'b0;
        sck = 1'b0;
        half_p();
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[31-i];
            half_p();
            rx[31-i] = miso;
            sck = 1'b1;
            half_p();
            rx_hi[31-i] = miso;
            if (i == mut_at) codes[mch] = mval;
            sck = 1'b0;
        end
        half_p();
        csel_n = 1'b1;
        repeat (6) @(negedge clk);
        idle_mon = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame_check(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                               input int mut_at, input int mch, input logic [CW-1:0] mval,
                               input string req);
        logic [31:0] exp, rx, rx_hi;
        exp = model(b0, b1);
        xfer({b0, b1, 8'hA5, 8'h5A}, nbits, mut_at, mch, mval, rx, rx_hi);
        chk("R1 first reply byte", {24'h0, rx[31:24]}, {24'h0, exp[31:24]});
        chk({req, " R6 high byte"}, {24'h0, rx[23:16]}, {24'h0, exp[23:16]});
        chk({req, " R6 low byte"}, {24'h0, rx[15:8]}, {24'h0, exp[15:8]});
        if (nbits == 32) chk("R9 byte after frame", {24'h0, rx[7:0]}, 32'h0);
        chk("R10 MISO steady in SCK high", rx_hi, rx);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        codes[0] = 10'h3FF; codes[1] = 10'h000; codes[2] = 10'h2AA; codes[3] = 10'h155;
        codes[4] = 10'h301; codes[5] = 10'h0FE; codes[6] = 10'h200; codes[7] = 10'h17C;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 reset MISO", {31'h0, miso}, 32'h0);

        // R5: every channel single-ended
        for (int c = 0; c < NCH; c++)
            frame_check(8'h01, {1'b1, 3'(c), 4'h0}, 24, -1, 0, '0, "R5");
        // low nibble of mode byte is don't-care
        frame_check(8'h01, 8'hAF, 24, -1, 0, '0, "R5");
        // R7: differential
        frame_check(8'h01, 8'h20, 24, -1, 0, '0, "R7");
        frame_check(8'h01, 8'h70, 24, -1, 0, '0, "R7");
        // R4: bad start bytes
        frame_check(8'h00, 8'h80, 24, -1, 0, '0, "R4");
        frame_check(8'h81, 8'h80, 24, -1, 0, '0, "R4");
        frame_check(8'h03, 8'hA0, 24, -1, 0, '0, "R4");
        frame_check(8'h11, 8'hC0, 24, -1, 0, '0, "R4");
        // R9: fourth byte reads zero
        frame_check(8'h01, 8'h80, 32, -1, 0, '0, "R9");
        // R8: code changes after the capture point
        frame_check(8'h01, 8'hB0, 24, 12, 3, 10'h2C3, "R8");
        frame_check(8'h01, 8'hB0, 24, -1, 0, '0, "R8 new value");

        // R3: host activity while deselected
        idle_mon = 1'b1;
        for (int k = 0; k < 12; k++) begin
            mosi = k[0];
            sck = k[1];
            repeat (3) @(negedge clk);
        end
        sck = 1'b0;
        repeat (4) @(negedge clk);
        frame_check(8'h01, 8'hE0, 24, -1, 0, '0, "R3");

        // R2: abort after five bits, then a clean frame
        begin
            logic [31:0] rx, rx_hi;
            xfer(32'hFFFF_FFFF, 5, -1, 0, '0, rx, rx_hi);
        end
        frame_check(8'h01, 8'hC0, 24, -1, 0, '0, "R2");
        frame_check(8'h01, 8'h90, 24, -1, 0, '0, "R2");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule